// File: doc/BRIEF.md
# Interval-Timer Bank Extension

This stage sits behind a five-bit serial bank controller and watches the register writes that controller commits. It keeps its own copies of the program mode field, the program bank field and the first character bank register. The character register is not used for character memory, which is fixed RAM here. Its five bits act as a control word for two things: a long-interval interrupt timer and an override of program banking.

The timer counts CPU cycle ticks in a wide counter. On each tick it adds one, then ORs the new count with a 4-bit board switch value placed just below the counter's top bit. When every bit of the top five positions of that OR is one, the counter returns to zero and the interrupt is raised. The switch setting therefore picks one of sixteen periods. Boards normally strap the switch to 0xE. Control bit 4 holds the counter at zero and also acknowledges the interrupt.

While control bit 3 is clear, program space is one 32K bank chosen by control bits 2:1, and the base controller's mode and bank fields have no effect. While bit 3 is set, the usual 16K window arrangement applies, but it is confined to the upper half of the 16K banks. Both window bank numbers come out as 16K bank indices, and they are updated on the clock edge that commits the relevant write.

Top module: `tmr_bank_ext`

## Requirements
- R1: After reset, irq_o is 0, the control word is 0, and the program mode is 3, so bank_lo_o=0 and bank_hi_o=1.
- R2: While control bit 3 is clear, bank_lo_o=2*b and bank_hi_o=2*b+1, where b is control bits 2:1. This holds whatever is in the mode and bank registers. Commits to select 2 change nothing.
- R3: While control bit 3 is set and mode (select 0, bits 3:2) is 3, bank_lo_o=8|(p&7) and bank_hi_o=15. Here p is the select 3 register, bits 3:0.
- R4: While control bit 3 is set and mode is 2, bank_lo_o=8 and bank_hi_o=8|(p&7).
- R5: While control bit 3 is set and mode is 0 or 1, bank_lo_o=8|(p&6) and bank_hi_o=8|(p&6)|1.
- R6: While control bit 4 is clear, each cycle with tick_i high advances the counter by one. Take a counter of width W with switch value d. The interrupt rises on the edge of tick N=2^(W-1)+((15-d)<<(W-5)), counted from a zero counter. Cycles with tick_i low do not count. For W=8, d=0xE gives N=136.
- R7: A control commit (select 1) with bit 4 set clears the counter and irq_o on that edge. While bit 4 stays set, the counter stays at zero regardless of ticks. Once bit 4 is cleared, counting starts again from zero.
- R8: Once raised, irq_o stays high through later counter wraps until an R7 acknowledge.
- R9: The control word takes its new value on every commit to select 1, and bank outputs reflect it from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | A register commit from the serial controller is present this cycle |
| wr_sel_i | input | 2 | Register select of the commit (0 mode, 1 control, 2 unused, 3 program bank) |
| wr_data_i | input | 5 | Committed 5-bit value |
| tick_i | input | 1 | One CPU cycle elapsed |
| dip_i | input | 4 | Board switch value that sets the timer period |
| irq_o | output | 1 | Interrupt request, held until acknowledged |
| bank_lo_o | output | 4 | 16K bank number for the lower program window |
| bank_hi_o | output | 4 | 16K bank number for the upper program window |

## Verification
The bench narrows the counter to 8 bits and sweeps all sixteen switch values. For each one it checks that the interrupt is still low one tick before the computed period and high on the tick itself. An off-by-one compare or a wrongly placed switch field would move that edge. A design that let the counter run while held would fire early after a long hold. One that cleared the interrupt on wrap would drop it during the sticky check. Ticks interleaved with idle cycles catch a counter that advances every clock. The bank sweep covers every control, mode and bank combination. Any leak of the mode or bank fields into 32K mode, or of bit 3 of the bank into restricted mode, would show up as a mismatch.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int BANK_W = 4;
  localparam int REG_W  = 5;

  typedef enum logic [1:0] {
    MODE_PAIR0  = 2'd0,
    MODE_PAIR1  = 2'd1,
    MODE_FIX_LO = 2'd2,
    MODE_FIX_HI = 2'd3
  } prg_mode_e;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_SPARE = 2'd2,
    SEL_PRG  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_bank_regs.sv
module tmr_bank_regs
  import tmr_bank_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output prg_mode_e           mode_o,
  output logic [BANK_W-1:0]   prg_o,
  output logic [REG_W-1:0]    ctl_o,
  output logic                ack_o
);
  prg_mode_e           mode_q;
  logic [BANK_W-1:0]   prg_q;
  logic [REG_W-1:0]    ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_FIX_HI;
      prg_q  <= '0;
      ctl_q  <= '0;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_sel_i))
        SEL_MODE: mode_q <= prg_mode_e'(wr_data_i[3:2]);
        SEL_CTL:  ctl_q  <= wr_data_i;
        SEL_PRG:  prg_q  <= wr_data_i[BANK_W-1:0];
        default:  ;
      endcase
    end
  end

  assign ack_o  = wr_en_i && (wr_sel_i == SEL_CTL) && wr_data_i[4];
  assign mode_o = mode_q;
  assign prg_o  = prg_q;
  assign ctl_o  = ctl_q;

  a_r9_ctl_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_CTL) |=> ctl_q == $past(wr_data_i));
endmodule

// File: rtl/tmr_interval.sv
module tmr_interval #(
  parameter int CNT_W = 30,
  parameter int DIP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             ack_i,
  input  logic             tick_i,
  input  logic [DIP_W-1:0] dip_i,
  output logic             irq_o
);
  localparam int TOP = CNT_W - 1;
  localparam int LOW = CNT_W - 1 - DIP_W;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             irq_q, hit;

  assign cnt_nxt = cnt_q + 1'b1;
  // switch bits sit just under the top bit; all five top bits must read one
  assign hit = cnt_nxt[TOP] & (&(cnt_nxt[TOP-1:LOW] | dip_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (ack_i) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (hold_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (hit) begin
        cnt_q <= '0;
        irq_q <= 1'b1;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign irq_o = irq_q;

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (!irq_o && cnt_q == '0));
  a_r7_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> cnt_q == '0);
  a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> irq_o);
  a_r6_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(tick_i) && !$past(hold_i)));
endmodule

// File: rtl/tmr_prg_map.sv
module tmr_prg_map
  import tmr_bank_pkg::*;
(
  input  prg_mode_e         mode_i,
  input  logic [BANK_W-1:0] prg_i,
  input  logic [3:1]        ctl_i,
  output logic [BANK_W-1:0] lo_o,
  output logic [BANK_W-1:0] hi_o
);
  localparam int SUB_W = BANK_W - 1;

  logic [SUB_W-1:0] sub;
  assign sub = prg_i[SUB_W-1:0];

  always_comb begin
    lo_o = '0;
    hi_o = '0;
    if (!ctl_i[3]) begin
      lo_o = BANK_W'({ctl_i[2:1], 1'b0});
      hi_o = BANK_W'({ctl_i[2:1], 1'b1});
    end else begin
      case (mode_i)
        MODE_FIX_HI: begin
          lo_o = {1'b1, sub};
          hi_o = {1'b1, {SUB_W{1'b1}}};
        end
        MODE_FIX_LO: begin
          lo_o = {1'b1, {SUB_W{1'b0}}};
          hi_o = {1'b1, sub};
        end
        default: begin
          lo_o = {1'b1, sub[SUB_W-1:1], 1'b0};
          hi_o = {1'b1, sub[SUB_W-1:1], 1'b1};
        end
      endcase
    end
  end
endmodule

// File: rtl/tmr_bank_ext.sv
module tmr_bank_ext
  import tmr_bank_pkg::*;
#(
  parameter int CNT_W = 30,
  parameter int DIP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [4:0]       wr_data_i,
  input  logic             tick_i,
  input  logic [DIP_W-1:0] dip_i,
  output logic             irq_o,
  output logic [3:0]       bank_lo_o,
  output logic [3:0]       bank_hi_o
);
  prg_mode_e         mode;
  logic [BANK_W-1:0] prg;
  logic [REG_W-1:0]  ctl;
  logic              ack;

  tmr_bank_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .mode_o(mode), .prg_o(prg), .ctl_o(ctl), .ack_o(ack)
  );

  tmr_interval #(.CNT_W(CNT_W), .DIP_W(DIP_W)) u_tmr (
    .clk_i, .rst_ni, .hold_i(ctl[4]), .ack_i(ack), .tick_i, .dip_i, .irq_o
  );

  tmr_prg_map u_map (
    .mode_i(mode), .prg_i(prg), .ctl_i(ctl[3:1]),
    .lo_o(bank_lo_o), .hi_o(bank_hi_o)
  );

  a_r2_pair_32k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl[3] |-> (!bank_lo_o[0] && bank_hi_o == bank_lo_o + 4'd1 && !bank_hi_o[3]));
  a_r3_upper_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl[3] |-> (bank_lo_o[3] && bank_hi_o[3]));
  a_r5_pair_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl[3] && !mode[1]) |-> (bank_hi_o == (bank_lo_o | 4'd1) && !bank_lo_o[0]));
endmodule

// File: tb/tb_tmr_bank_ext.sv
module tb_tmr_bank_ext;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [4:0] wr_data = '0;
  logic tick = 1'b0;
  logic [3:0] dip = 4'hE;
  logic irq;
  logic [3:0] lo, hi;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_bank_ext #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .tick_i(tick), .dip_i(dip), .irq_o(irq),
    .bank_lo_o(lo), .bank_hi_o(hi)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 5'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  function automatic int period(int d);
    return (1 << (CW - 1)) + ((15 - d) << (CW - 5));
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_lo, exp_hi, s, n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 lo", int'(lo), 0);
    chk("R1 hi", int'(hi), 1);

    // R2..R5, R9: full bank sweep with timer held
    for (int m = 0; m < 4; m++) begin
      wr(0, m << 2);
      for (int p = 0; p < 16; p++) begin
        wr(3, p);
        for (int c = 0; c < 16; c++) begin
          wr(1, 16 | c);
          s = p & 7;
          if (!c[3]) begin
            exp_lo = ((c >> 1) & 3) * 2; exp_hi = exp_lo + 1;
            chk("R2 lo", int'(lo), exp_lo); chk("R2 hi", int'(hi), exp_hi);
          end else if (m == 3) begin
            chk("R3 lo", int'(lo), 8 | s); chk("R3 hi", int'(hi), 15);
          end else if (m == 2) begin
            chk("R4 lo", int'(lo), 8); chk("R4 hi", int'(hi), 8 | s);
          end else begin
            chk("R5 lo", int'(lo), 8 | (s & 6)); chk("R5 hi", int'(hi), 8 | (s & 6) | 1);
          end
        end
      end
    end
    // R2: select 2 commit has no effect
    wr(0, 12); wr(3, 5); wr(1, 16 | 4);
    wr(2, 31);
    chk("R2 spare lo", int'(lo), 4);
    chk("R2 spare hi", int'(hi), 5);
    // R9: control change re-evaluates banks next cycle
    wr(1, 16 | 8);
    chk("R9 lo", int'(lo), 13);
    chk("R9 hi", int'(hi), 15);

    // R6, R7, R8: timer sweep over all switch values
    for (int d = 0; d < 16; d++) begin
      dip = 4'(d);
      n = period(d);
      wr(1, 16);
      chk("R7 ack irq", int'(irq), 0);
      ticks(300, 0);
      chk("R7 held irq", int'(irq), 0);
      wr(1, 0);
      if (d == 14) begin
        ticks(n - 1, 1);
      end else begin
        ticks(n - 1, 0);
      end
      chk("R6 before period", int'(irq), 0);
      ticks(1, 0);
      chk("R6 at period", int'(irq), 1);
      ticks(n + 3, 0);
      chk("R8 sticky", int'(irq), 1);
    end
    // R6: idle cycles do not advance; R7: ack then restart from zero
    dip = 4'hE;
    n = period(14);
    wr(1, 16);
    chk("R7 ack", int'(irq), 0);
    wr(1, 0);
    ticks(n - 2, 0);
    repeat (50) @(negedge clk);
    ticks(1, 0);
    chk("R6 idle no count", int'(irq), 0);
    ticks(1, 0);
    chk("R6 default period", int'(irq), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule